// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a memory space with a small table of region descriptors and judges every bus access against them in the cycle the access is presented. Each descriptor holds a lower bound, an upper bound, a rights word and a valid flag. An access brings an address, the number of the requesting master, a supervisor/user mode flag and a kind: read, write or execute. The block answers with a grant, an error pulse when the access is refused, and a one-hot map of the regions whose address window contains the address.

Two classes of masters exist. The low-numbered masters carry two read/write/execute groups, one for user mode and one for supervisor mode. The high-numbered masters carry only a read enable and a write enable. Region bounds are compared at 32-byte granularity. Descriptor 0 comes out of reset covering the whole space with full rights, and its bounds and the debug master's rights cannot be rewritten. The other descriptors come out of reset empty and invalid. A single enable switches checking on; while it is off every access is granted.

Descriptors are written one field per cycle through a select/field/data write port. A separate field code gives a partial rights update that touches one master's bits only.

Top module: `mpuRegionCheck`

## Requirements
- R1: After reset protection is off, descriptor 0 is valid with bounds 0x00000000 to 0xFFFFFFFF and all rights bits set, and descriptors 1 to 7 are invalid with zero bounds and zero rights; a valid access then is granted with hit map 0x01.
- R2: A region's lower bound is its stored start address with bits [4:0] taken as zero.
- R3: A region's upper bound is its stored end address with bits [4:0] taken as ones; an address one above it is outside the region.
- R4: Masters 0 to 3 own rights bits [6m+5:6m] (m = master); bits [6m+2:6m] are the user group and bits [6m+5:6m+3] the supervisor group, each ordered read (upper), write, execute (lower); accSuper selects the group.
- R5: Masters 4 to 7 own rights bits [24+2(m-4)+1 : 24+2(m-4)], read enable in the upper bit and write enable in the lower bit; an execute access from these masters is never granted while protection is on.
- R6: Only descriptors whose valid flag (field code 3, data bit 0) is set appear in the hit map or grant rights.
- R7: On descriptor 0, writes of the start (field code 0) or end (field code 1) have no effect, and rights writes (field code 2) or partial rights writes (field code 4) leave the debug master 1 field unchanged while other masters' fields are updated.
- R8: A partial rights write (field code 4) takes the master number from data bits [10:8] and the new field value from data bits [5:0] (low bits of it for a 2-bit field), and changes only that master's field in the selected descriptor.
- R9: The enable (field code 5, data bit 0) switches protection; while it is 0 every valid access is granted, and the hit map is still reported.
- R10: With protection on, an access is granted exactly when at least one valid region containing the address gives the master the requested right in the current mode; overlapping regions combine their rights by OR.
- R11: accErr is high in the same cycle as a valid access that is not granted; with accValid low, accGrant, accErr and the hit map are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Descriptor write strobe |
| cfgField | input | 3 | Field code: 0 start, 1 end, 2 rights, 3 valid, 4 partial rights, 5 enable |
| cfgSel | input | 3 | Descriptor number written |
| cfgWrData | input | 32 | Write data |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Access address |
| accMaster | input | 3 | Requesting master number |
| accSuper | input | 1 | 1 = supervisor mode, 0 = user mode |
| accKind | input | 2 | 0 read, 1 write, 2 execute |
| accGrant | output | 1 | Access allowed |
| accErr | output | 1 | Access refused, same cycle |
| accHitMap | output | 8 | One-hot per region whose window holds the address |

## Verification
Accesses are aimed just inside and just outside region edges with unaligned stored bounds, which separates correct 32-byte masking from plain comparison. The same address is tried with each mode and kind for a low master and with each kind for a high master, which tells apart a swapped user/supervisor group, a swapped read/write order and a missing execute lock-out. Two overlapping regions that each grant a different right to one master show whether rights are ORed rather than taken from the first hit, and writes to locked and unlocked fields of descriptor 0 and partial rights writes are followed by accesses that expose any bit that changed when it should not.

// File: rtl/mpuChkPkg.sv
package mpuChkPkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2
  } accKind_e;

  typedef enum logic [2:0] {
    FLD_START  = 3'd0,
    FLD_END    = 3'd1,
    FLD_RIGHTS = 3'd2,
    FLD_VALID  = 3'd3,
    FLD_ALT    = 3'd4,
    FLD_ENABLE = 3'd5
  } cfgField_e;

  // strobes from the write decoder to the descriptor table
  typedef struct packed {
    logic wrStart;
    logic wrEnd;
    logic wrRights;
    logic wrValid;
    logic wrAlt;
    logic wrEnable;
  } cfgStrobes_t;

  localparam int LOW_FIELD_W  = 6;
  localparam int HIGH_FIELD_W = 2;
  localparam int GROUP_W      = 3;
  localparam int ALT_MST_LSB  = 8;

  function automatic int fieldLsb(input int m, input int low);
    return (m < low) ? m * LOW_FIELD_W : low * LOW_FIELD_W + (m - low) * HIGH_FIELD_W;
  endfunction

  function automatic int fieldWidth(input int m, input int low);
    return (m < low) ? LOW_FIELD_W : HIGH_FIELD_W;
  endfunction

  function automatic logic [63:0] fieldMask(input int m, input int low);
    return ((64'd1 << fieldWidth(m, low)) - 64'd1) << fieldLsb(m, low);
  endfunction

endpackage

// File: rtl/regionCtrl.sv
module regionCtrl
  import mpuChkPkg::*;
#(
  parameter int IDX_W = 3
) (
  input  logic             cfgWrEn,
  input  logic [2:0]       cfgField,
  input  logic [IDX_W-1:0] cfgSel,
  output cfgStrobes_t      strb
);

  logic selLocked;
  assign selLocked = (cfgSel == '0);

  always_comb begin
    strb = '0;
    if (cfgWrEn) begin
      case (cfgField_e'(cfgField))
        FLD_START:  strb.wrStart  = !selLocked;
        FLD_END:    strb.wrEnd    = !selLocked;
        FLD_RIGHTS: strb.wrRights = 1'b1;
        FLD_VALID:  strb.wrValid  = 1'b1;
        FLD_ALT:    strb.wrAlt    = 1'b1;
        FLD_ENABLE: strb.wrEnable = 1'b1;
        default:    strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/regionTable.sv
module regionTable
  import mpuChkPkg::*;
#(
  parameter int REGIONS      = 8,
  parameter int MASTERS      = 8,
  parameter int LOW_MASTERS  = 4,
  parameter int DEBUG_MASTER = 1,
  parameter int ADDR_W       = 32,
  parameter int RIGHTS_W     = 32,
  parameter int DATA_W       = 32,
  parameter int IDX_W        = 3,
  parameter int MST_W        = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  cfgStrobes_t                       strb,
  input  logic [IDX_W-1:0]                  cfgSel,
  input  logic [DATA_W-1:0]                 cfgWrData,
  output logic [REGIONS-1:0][ADDR_W-1:0]    startVec,
  output logic [REGIONS-1:0][ADDR_W-1:0]    endVec,
  output logic [REGIONS-1:0][RIGHTS_W-1:0]  rightsVec,
  output logic [REGIONS-1:0]                validVec,
  output logic                              protEn
);

  localparam logic [63:0] DBG_MASK64 = fieldMask(DEBUG_MASTER, LOW_MASTERS);
  localparam logic [RIGHTS_W-1:0] DBG_MASK = DBG_MASK64[RIGHTS_W-1:0];

  logic [MST_W-1:0]    altMaster;
  logic [63:0]         altMask64;
  logic [63:0]         altShift;
  logic [RIGHTS_W-1:0] altMask;
  logic [RIGHTS_W-1:0] altVal;

  assign altMaster = cfgWrData[ALT_MST_LSB +: MST_W];

  always_comb begin
    altMask64 = '0;
    altShift  = '0;
    if (int'(altMaster) < MASTERS) begin
      altMask64 = fieldMask(int'(altMaster), LOW_MASTERS);
      altShift  = {58'd0, cfgWrData[5:0]} << fieldLsb(int'(altMaster), LOW_MASTERS);
    end
    altMask = altMask64[RIGHTS_W-1:0];
    altVal  = altShift[RIGHTS_W-1:0];
  end

  for (genvar r = 0; r < REGIONS; r++) begin : gRegion
    localparam logic [RIGHTS_W-1:0] KEEP = (r == 0) ? DBG_MASK : '0;
    logic hereSel;
    assign hereSel = (int'(cfgSel) == r);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        startVec[r]  <= '0;
        endVec[r]    <= (r == 0) ? {ADDR_W{1'b1}} : {ADDR_W{1'b0}};
        rightsVec[r] <= (r == 0) ? {RIGHTS_W{1'b1}} : {RIGHTS_W{1'b0}};
        validVec[r]  <= (r == 0);
      end else if (hereSel) begin
        if (strb.wrStart) startVec[r] <= cfgWrData[ADDR_W-1:0];
        if (strb.wrEnd)   endVec[r]   <= cfgWrData[ADDR_W-1:0];
        if (strb.wrValid) validVec[r] <= cfgWrData[0];
        if (strb.wrRights)
          rightsVec[r] <= (cfgWrData[RIGHTS_W-1:0] & ~KEEP) | (rightsVec[r] & KEEP);
        else if (strb.wrAlt)
          rightsVec[r] <= (rightsVec[r] & ~(altMask & ~KEEP)) | (altVal & altMask & ~KEEP);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             protEn <= 1'b0;
    else if (strb.wrEnable) protEn <= cfgWrData[0];
  end

endmodule

// File: rtl/accessJudge.sv
module accessJudge
  import mpuChkPkg::*;
#(
  parameter int REGIONS     = 8,
  parameter int MASTERS     = 8,
  parameter int LOW_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int RIGHTS_W    = 32,
  parameter int GRAN_BITS   = 5,
  parameter int MST_W       = 3
) (
  input  logic [REGIONS-1:0][ADDR_W-1:0]   startVec,
  input  logic [REGIONS-1:0][ADDR_W-1:0]   endVec,
  input  logic [REGIONS-1:0][RIGHTS_W-1:0] rightsVec,
  input  logic [REGIONS-1:0]               validVec,
  input  logic                             protEn,
  input  logic                             accValid,
  input  logic [ADDR_W-1:0]                accAddr,
  input  logic [MST_W-1:0]                 accMaster,
  input  logic                             accSuper,
  input  logic [1:0]                       accKind,
  output logic                             accGrant,
  output logic                             accErr,
  output logic [REGIONS-1:0]               accHitMap
);

  logic               lowClass;
  logic               masterOk;
  int                 reqLsb;
  logic [REGIONS-1:0] hit;
  logic [REGIONS-1:0] allow;

  always_comb begin
    masterOk = (int'(accMaster) < MASTERS);
    lowClass = (int'(accMaster) < LOW_MASTERS);
    reqLsb   = masterOk ? fieldLsb(int'(accMaster), LOW_MASTERS) : 0;
  end

  for (genvar r = 0; r < REGIONS; r++) begin : gMatch
    logic [ADDR_W-1:0]  lo;
    logic [ADDR_W-1:0]  hi;
    logic [GROUP_W-1:0] grp;
    logic [1:0]         pair;
    logic               okR;

    assign lo     = {startVec[r][ADDR_W-1:GRAN_BITS], {GRAN_BITS{1'b0}}};
    assign hi     = {endVec[r][ADDR_W-1:GRAN_BITS], {GRAN_BITS{1'b1}}};
    assign hit[r] = validVec[r] && (accAddr >= lo) && (accAddr <= hi);

    always_comb begin
      grp  = '0;
      pair = '0;
      okR  = 1'b0;
      if (masterOk) begin
        if (lowClass) begin
          grp = rightsVec[r][reqLsb + (accSuper ? GROUP_W : 0) +: GROUP_W];
          case (accKind_e'(accKind))
            ACC_READ:  okR = grp[2];
            ACC_WRITE: okR = grp[1];
            ACC_EXEC:  okR = grp[0];
            default:   okR = 1'b0;
          endcase
        end else begin
          pair = rightsVec[r][reqLsb +: 2];
          case (accKind_e'(accKind))
            ACC_READ:  okR = pair[1];
            ACC_WRITE: okR = pair[0];
            default:   okR = 1'b0;
          endcase
        end
      end
    end

    assign allow[r] = hit[r] && okR;
  end

  assign accHitMap = accValid ? hit : '0;
  assign accGrant  = accValid && (!protEn || (|allow));
  assign accErr    = accValid && !accGrant;

endmodule

// File: rtl/mpuRegionCheck.sv
module mpuRegionCheck
  import mpuChkPkg::*;
#(
  parameter int REGIONS      = 8,
  parameter int MASTERS      = 8,
  parameter int LOW_MASTERS  = 4,
  parameter int DEBUG_MASTER = 1,
  parameter int ADDR_W       = 32,
  parameter int GRAN_BITS    = 5,
  localparam int RIGHTS_W    = LOW_MASTERS * LOW_FIELD_W + (MASTERS - LOW_MASTERS) * HIGH_FIELD_W,
  localparam int DATA_W      = (ADDR_W > RIGHTS_W) ? ADDR_W : RIGHTS_W,
  localparam int IDX_W       = (REGIONS > 1) ? $clog2(REGIONS) : 1,
  localparam int MST_W       = (MASTERS > 1) ? $clog2(MASTERS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [2:0]         cfgField,
  input  logic [IDX_W-1:0]   cfgSel,
  input  logic [DATA_W-1:0]  cfgWrData,
  input  logic               accValid,
  input  logic [ADDR_W-1:0]  accAddr,
  input  logic [MST_W-1:0]   accMaster,
  input  logic               accSuper,
  input  logic [1:0]         accKind,
  output logic               accGrant,
  output logic               accErr,
  output logic [REGIONS-1:0] accHitMap
);

  cfgStrobes_t                      strb;
  logic [REGIONS-1:0][ADDR_W-1:0]   startVec;
  logic [REGIONS-1:0][ADDR_W-1:0]   endVec;
  logic [REGIONS-1:0][RIGHTS_W-1:0] rightsVec;
  logic [REGIONS-1:0]               validVec;
  logic                             protEn;

  regionCtrl #(.IDX_W(IDX_W)) u_ctrl (
    .cfgWrEn (cfgWrEn),
    .cfgField(cfgField),
    .cfgSel  (cfgSel),
    .strb    (strb)
  );

  regionTable #(
    .REGIONS(REGIONS), .MASTERS(MASTERS), .LOW_MASTERS(LOW_MASTERS),
    .DEBUG_MASTER(DEBUG_MASTER), .ADDR_W(ADDR_W), .RIGHTS_W(RIGHTS_W),
    .DATA_W(DATA_W), .IDX_W(IDX_W), .MST_W(MST_W)
  ) u_table (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgSel   (cfgSel),
    .cfgWrData(cfgWrData),
    .startVec (startVec),
    .endVec   (endVec),
    .rightsVec(rightsVec),
    .validVec (validVec),
    .protEn   (protEn)
  );

  accessJudge #(
    .REGIONS(REGIONS), .MASTERS(MASTERS), .LOW_MASTERS(LOW_MASTERS),
    .ADDR_W(ADDR_W), .RIGHTS_W(RIGHTS_W), .GRAN_BITS(GRAN_BITS), .MST_W(MST_W)
  ) u_judge (
    .startVec (startVec),
    .endVec   (endVec),
    .rightsVec(rightsVec),
    .validVec (validVec),
    .protEn   (protEn),
    .accValid (accValid),
    .accAddr  (accAddr),
    .accMaster(accMaster),
    .accSuper (accSuper),
    .accKind  (accKind),
    .accGrant (accGrant),
    .accErr   (accErr),
    .accHitMap(accHitMap)
  );

endmodule

// File: rtl/regionCheckSva.sv
module regionCheckSva
  import mpuChkPkg::*;
#(
  parameter int REGIONS     = 8,
  parameter int MASTERS     = 8,
  parameter int LOW_MASTERS = 4,
  parameter int ADDR_W      = 32,
  parameter int RIGHTS_W    = 32,
  parameter int DATA_W      = 32,
  parameter int IDX_W       = 3,
  parameter int MST_W       = 3
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             cfgWrEn,
  input logic [2:0]                       cfgField,
  input logic [IDX_W-1:0]                 cfgSel,
  input logic [DATA_W-1:0]                cfgWrData,
  input logic                             accValid,
  input logic [MST_W-1:0]                 accMaster,
  input logic [1:0]                       accKind,
  input logic                             accGrant,
  input logic                             accErr,
  input logic [REGIONS-1:0]               accHitMap,
  input logic [REGIONS-1:0][ADDR_W-1:0]   startVec,
  input logic [REGIONS-1:0][ADDR_W-1:0]   endVec,
  input logic [REGIONS-1:0][RIGHTS_W-1:0] rightsVec,
  input logic [REGIONS-1:0]               validVec,
  input logic                             protEn
);

  // capture for the partial-rights check (R8)
  logic                altPend;
  logic [IDX_W-1:0]    altSelQ;
  logic [RIGHTS_W-1:0] keepMaskQ;
  logic [RIGHTS_W-1:0] keepValQ;
  logic [63:0]         curMask64;
  logic [RIGHTS_W-1:0] curMask;

  always_comb begin
    curMask64 = '0;
    if (int'(cfgWrData[ALT_MST_LSB +: MST_W]) < MASTERS)
      curMask64 = fieldMask(int'(cfgWrData[ALT_MST_LSB +: MST_W]), LOW_MASTERS);
    curMask = curMask64[RIGHTS_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      altPend   <= 1'b0;
      altSelQ   <= '0;
      keepMaskQ <= '0;
      keepValQ  <= '0;
    end else begin
      altPend   <= cfgWrEn && (cfgField == 3'd4);
      altSelQ   <= cfgSel;
      keepMaskQ <= ~curMask;
      keepValQ  <= rightsVec[cfgSel] & ~curMask;
    end
  end

  assert_alt_others_R8: assert property (@(posedge clk) disable iff (!rstN)
    altPend |-> ((rightsVec[altSelQ] & keepMaskQ) == keepValQ));

  assert_off_grant_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !protEn) |-> accGrant);

  assert_hit_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accHitMap & ~validVec) == '0);

  assert_exec_high_R5: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && protEn && (int'(accMaster) >= LOW_MASTERS) && (accKind == 2'd2)) |-> !accGrant);

  assert_grant_hit_R10: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && protEn && accGrant) |-> (accHitMap != '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accGrant && !accErr && accHitMap == '0));

  assert_err_denied_R11: assert property (@(posedge clk) disable iff (!rstN)
    accErr |-> (accValid && !accGrant));

  assert_r0_bounds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgSel == '0 && (cfgField == 3'd0 || cfgField == 3'd1))
      |=> ($stable(startVec[0]) && $stable(endVec[0])));

endmodule

bind mpuRegionCheck regionCheckSva #(
  .REGIONS(REGIONS), .MASTERS(MASTERS), .LOW_MASTERS(LOW_MASTERS),
  .ADDR_W(ADDR_W), .RIGHTS_W(RIGHTS_W), .DATA_W(DATA_W),
  .IDX_W(IDX_W), .MST_W(MST_W)
) u_sva (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgField(cfgField),
  .cfgSel(cfgSel), .cfgWrData(cfgWrData), .accValid(accValid),
  .accMaster(accMaster), .accKind(accKind), .accGrant(accGrant),
  .accErr(accErr), .accHitMap(accHitMap), .startVec(startVec),
  .endVec(endVec), .rightsVec(rightsVec), .validVec(validVec),
  .protEn(protEn)
);

// File: tb/sim_mpuRegionCheck.sv
`timescale 1ns/1ps
module sim_mpuRegionCheck;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgField = '0;
  logic [2:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic [2:0]  accMaster = '0;
  logic        accSuper = 1'b0;
  logic [1:0]  accKind = '0;
  logic        accGrant;
  logic        accErr;
  logic [7:0]  accHitMap;

  mpuRegionCheck u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgField(cfgField),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .accValid(accValid),
    .accAddr(accAddr), .accMaster(accMaster), .accSuper(accSuper),
    .accKind(accKind), .accGrant(accGrant), .accErr(accErr),
    .accHitMap(accHitMap)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic       grant;
    logic       err;
    logic [7:0] hit;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  logic     busy = 1'b0;
  int       nChecks = 0;
  int       nFails = 0;
  bit       finished = 1'b0;

  // bench-side descriptor model, built from the requirement text
  logic [31:0] mStart [8];
  logic [31:0] mEnd   [8];
  logic [31:0] mRights[8];
  logic        mValid [8];
  logic        mEn;

  localparam int RD = 0, WR = 1, EX = 2;

  function automatic int lsbOf(input int m);
    return (m < 4) ? m * 6 : 24 + (m - 4) * 2;
  endfunction

  function automatic logic [31:0] maskOf(input int m);
    return ((m < 4) ? 32'h3F : 32'h3) << lsbOf(m);
  endfunction

  task automatic modelReset();
    for (int r = 0; r < 8; r++) begin
      mStart[r]  = '0;
      mEnd[r]    = (r == 0) ? 32'hFFFF_FFFF : 32'h0;
      mRights[r] = (r == 0) ? 32'hFFFF_FFFF : 32'h0;
      mValid[r]  = (r == 0);
    end
    mEn = 1'b0;
  endtask

  task automatic cfgWrite(input int fld, input int sel, input logic [31:0] data);
    logic [31:0] keep;
    logic [31:0] mk;
    int m;
    keep = (sel == 0) ? maskOf(1) : 32'h0;
    case (fld)
      0: if (sel != 0) mStart[sel] = data;
      1: if (sel != 0) mEnd[sel] = data;
      2: mRights[sel] = (data & ~keep) | (mRights[sel] & keep);
      3: mValid[sel] = data[0];
      4: begin
        m  = int'(data[10:8]);
        mk = maskOf(m) & ~keep;
        mRights[sel] = (mRights[sel] & ~mk) | ((32'(data[5:0]) << lsbOf(m)) & mk);
      end
      5: mEn = data[0];
      default: ;
    endcase
    @(posedge clk); #1;
    cfgWrEn = 1'b1; cfgField = 3'(fld); cfgSel = 3'(sel); cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0;
  endtask

  function automatic logic rightOf(input logic [31:0] rw, input int m, input bit sup, input int kind);
    logic [2:0] g;
    logic [1:0] p;
    if (m < 4) begin
      g = rw[lsbOf(m) + (sup ? 3 : 0) +: 3];
      return (kind == RD) ? g[2] : (kind == WR) ? g[1] : g[0];
    end
    p = rw[lsbOf(m) +: 2];
    return (kind == RD) ? p[1] : (kind == WR) ? p[0] : 1'b0;
  endfunction

  task automatic access(input bit vld, input logic [31:0] addr, input int m,
                        input bit sup, input int kind, input string tag);
    expItem_t e;
    logic any;
    e.hit = '0;
    any = 1'b0;
    for (int r = 0; r < 8; r++) begin
      if (mValid[r] && addr >= (mStart[r] & ~32'h1F) && addr <= (mEnd[r] | 32'h1F)) begin
        e.hit[r] = 1'b1;
        if (rightOf(mRights[r], m, sup, kind)) any = 1'b1;
      end
    end
    if (!vld) e.hit = '0;
    e.grant = vld && (!mEn || any);
    e.err   = vld && !e.grant;
    e.tag   = tag;
    @(posedge clk); #1;
    accValid = vld; accAddr = addr; accMaster = 3'(m);
    accSuper = sup; accKind = 2'(kind);
    expQ.push_back(e);
    busy = 1'b1;
    @(posedge clk); #1;
    busy = 1'b0;
    accValid = 1'b0;
  endtask

  // monitor: compares the design's answer in the middle of the access cycle
  always @(negedge clk) begin
    if (busy && expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      nChecks++;
      if (accGrant !== e.grant || accErr !== e.err || accHitMap !== e.hit) begin
        nFails++;
        $display("FAIL %s: grant/err/hit = %b/%b/%02h expected %b/%b/%02h",
                 e.tag, accGrant, accErr, accHitMap, e.grant, e.err, e.hit);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish();
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (accGrant !== 1'b0 || accErr !== 1'b0 || accHitMap !== 8'h00) begin
      nFails++;
      $display("FAIL R1 reset idle: %b/%b/%02h expected 0/0/00", accGrant, accErr, accHitMap);
    end

    // R1: reset table, protection off then on
    access(1, 32'h0000_1234, 3, 0, RD, "R1 reset read");
    access(1, 32'hFFFF_FFFF, 6, 0, WR, "R1 top address");
    access(0, 32'h0000_0040, 2, 1, WR, "R11 idle");
    cfgWrite(5, 0, 32'h1);
    access(1, 32'h0000_0800, 3, 1, EX, "R1 full rights region 0");
    access(1, 32'h0000_0800, 7, 0, EX, "R5 exec high master");

    // R7: descriptor 0 protection
    cfgWrite(0, 0, 32'h0000_1000);
    cfgWrite(1, 0, 32'h0000_1FFF);
    access(1, 32'h0000_0000, 0, 0, RD, "R7 bounds kept");
    cfgWrite(2, 0, 32'h0);
    access(1, 32'h0000_0040, 0, 0, RD, "R7 master0 cleared");
    access(1, 32'h0000_0040, 1, 0, RD, "R7 debug kept");
    access(1, 32'h0000_0040, 5, 0, RD, "R7 master5 cleared");
    cfgWrite(4, 0, 32'h0000_0100);
    access(1, 32'h0000_0040, 1, 1, WR, "R7 debug partial write ignored");

    // region 2 with unaligned stored bounds
    cfgWrite(0, 2, 32'h2000_0013);
    cfgWrite(1, 2, 32'h2000_00E0);
    cfgWrite(2, 2, 32'h0800_003C);
    cfgWrite(3, 2, 32'h1);
    access(1, 32'h2000_0000, 0, 0, RD, "R2 lower edge");
    access(1, 32'h1FFF_FFFF, 0, 0, RD, "R2 below");
    access(1, 32'h2000_00FF, 0, 0, RD, "R3 upper edge");
    access(1, 32'h2000_0100, 0, 0, RD, "R3 above");

    // R4: user versus supervisor groups
    access(1, 32'h2000_0010, 0, 0, WR, "R4 user write");
    access(1, 32'h2000_0010, 0, 0, EX, "R4 user exec");
    access(1, 32'h2000_0010, 0, 1, WR, "R4 super write");
    access(1, 32'h2000_0010, 0, 1, EX, "R4 super exec");

    // R5: high master read/write pair
    access(1, 32'h2000_0010, 5, 0, RD, "R5 read");
    access(1, 32'h2000_0010, 5, 0, WR, "R5 write");
    access(1, 32'h2000_0010, 5, 1, EX, "R5 exec");

    // R6: valid flag
    cfgWrite(0, 3, 32'h3000_0000);
    cfgWrite(1, 3, 32'h3000_0FFF);
    cfgWrite(2, 3, 32'hFFFF_FFFF);
    access(1, 32'h3000_0100, 0, 0, RD, "R6 invalid region");
    cfgWrite(3, 3, 32'h1);
    access(1, 32'h3000_0100, 0, 0, RD, "R6 valid region");
    cfgWrite(3, 3, 32'h0);
    access(1, 32'h3000_0100, 0, 0, RD, "R6 invalidated");

    // R8: partial rights write on master 5 of region 2
    cfgWrite(4, 2, 32'h0000_0501);
    access(1, 32'h2000_0010, 5, 0, WR, "R8 new write");
    access(1, 32'h2000_0010, 5, 0, RD, "R8 read removed");
    access(1, 32'h2000_0010, 0, 1, WR, "R8 master0 unchanged");
    access(1, 32'h2000_0010, 0, 0, WR, "R8 master0 user unchanged");

    // R10: overlapping regions OR their rights
    cfgWrite(0, 4, 32'h2000_0000);
    cfgWrite(1, 4, 32'h2000_003F);
    cfgWrite(2, 4, 32'h0800_0000);
    cfgWrite(3, 4, 32'h1);
    access(1, 32'h2000_0020, 5, 0, RD, "R10 read from region 4");
    access(1, 32'h2000_0020, 5, 0, WR, "R10 write from region 2");
    access(1, 32'h2000_0040, 5, 0, RD, "R10 outside region 4");

    // R9: protection off
    cfgWrite(5, 0, 32'h0);
    access(1, 32'h1FFF_FFFF, 0, 0, WR, "R9 off grants");
    access(1, 32'h2000_0020, 5, 0, EX, "R9 off exec");
    access(0, 32'h2000_0020, 5, 0, RD, "R11 idle after");

    repeat (3) @(posedge clk);
    finish();
  end

endmodule